// File: doc/BRIEF.md
# DRAM Burst Termination Controller

This controller sits on the command side of a single-rank double-data-rate memory interface. It starts read and write bursts, keeps track of the one burst in progress, and accepts requests to cut that burst short with either a precharge or a burst-stop. It drives a registered command bus and three timing strobes. `rd_valid` marks the cycles in which returned read data may be captured. `wr_window` marks the cycles in which write data is driven. `wr_mask` is the data-mask level that keeps leftover write data out of the array after an interruption.

Read and write bursts end by different rules. A read that is cut off keeps delivering data for one CAS latency after the terminating command. A write that is cut off loses its data window in the very cycle of the precharge, and the mask is then held high for the write-recovery count. A burst-stop is only accepted for a read. Requests that cannot be honoured raise a one-cycle error flag and put nothing on the command bus.

CAS latency, burst length and write recovery come from configuration inputs. Their values are captured when a burst starts, so changing them during a burst does not alter that burst.

Top module: `burst_term_ctrl`

## Requirements
- R1: An accepted request sampled at a clock edge appears on the command bus for exactly the following cycle, with `cmd_valid` high, `cmd_bank` equal to the request's bank and `cmd_op` coded NOP=0, READ=1, WRITE=2, PRECHARGE=3, BURST_STOP=4. The `req_op` codes are read=0, write=1, precharge=2, stop=3.
- R2: Counting the READ command cycle as cycle 0, an uninterrupted read holds `rd_valid` high from cycle L through cycle L+H-1. L is 2 for `cfg_cl`=0 and 3 for `cfg_cl`=1 (2.5 rounded up), 2 or 3. H is 1, 2 or 4 for `cfg_bl`=0, 1 or 2/3 (2, 4 or 8 beats).
- R3: A precharge or burst-stop to the reading bank that lands on the command bus in cycle P ends the read. The last cycle with `rd_valid` high is then the smaller of L+H-1 and P+L-1.
- R4: Counting the WRITE command cycle as cycle 0, an uninterrupted write holds `wr_window` high in cycles 1 through H, keeps `wr_mask` low and never raises `rd_valid`.
- R5: A precharge to the writing bank on the command bus in cycle P drops `wr_window` from cycle P onward.
- R6: After such a precharge, `wr_mask` is high for exactly T cycles starting in cycle P, where T is `cfg_twr` captured at the start of the write (0 counts as 1). `wr_mask` and `wr_window` are never high together.
- R7: A stop request during a write puts no command on the bus and raises `err` in the cycle a command would have used. The write keeps its full window.
- R8: A stop request with no live read burst in that bank raises `err` for one cycle and leaves `cmd_valid` low.
- R9: A read or write request while a burst (including its drain or mask time) is in progress is refused with `err` and no command. The running burst is unchanged.
- R10: A precharge to another bank, or with no burst live, is issued on the command bus without `err` and does not change the running burst.
- R11: While `rst_n` is sampled low, all outputs go low on the next cycle and any burst is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request kind: 0 read, 1 write, 2 precharge, 3 stop |
| req_bank | input | BANK_W | Target bank |
| cfg_cl | input | 2 | CAS latency code (0: 2, 1: 2.5, 2/3: 3) |
| cfg_bl | input | 2 | Burst length code (0: 2, 1: 4, 2/3: 8 beats) |
| cfg_twr | input | TWR_W | Write-recovery cycles for the mask |
| cmd_valid | output | 1 | Command on the bus this cycle |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| err | output | 1 | Request refused this cycle |
| rd_valid | output | 1 | Read data valid window |
| wr_window | output | 1 | Write data drive window |
| wr_mask | output | 1 | Write data mask level |

## Verification
The bound checker watches every cycle for exclusivity properties. It confirms that a refusal and a command never share a cycle, that the read window never overlaps the write window or the mask, and that the mask and the write window never coincide. It also checks that the mask only ever rises in a cycle that carries a precharge, that a burst-stop never appears while a write is driving or masked, and that reset clears all outputs. The exact cycles at which the read window ends and the mask window spans depend on the programmed latency, burst length and recovery count. Only the bench's scenarios can show those, by measuring the first and last active cycles against values worked out from the requirements.

// File: rtl/bt_pkg.sv
// Shared codes for the burst termination controller.
// Assumes a 2-bit request opcode and a 3-bit command opcode.
package bt_pkg;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_PRE   = 2'd2,
        REQ_STOP  = 2'd3
    } req_op_e;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_PRE   = 3'd3,
        CMD_BST   = 3'd4
    } cmd_op_e;

endpackage

// File: rtl/bt_cfg_decode.sv
// Turns the configuration codes into cycle counts.
// Assumes CAS latency in half-cycle steps is rounded up to whole cycles,
// data moves two beats per cycle, and a zero recovery count means one.
module bt_cfg_decode #(
    parameter int TWR_W = 4,
    parameter int AGE_W = TWR_W + 3
) (
    input  logic [1:0]       cl_code,
    input  logic [1:0]       bl_code,
    input  logic [TWR_W-1:0] twr_code,
    output logic [AGE_W-1:0] lat_cyc,
    output logic [AGE_W-1:0] half_cyc,
    output logic [AGE_W-1:0] twr_cyc
);
    localparam int PAD_W = AGE_W - TWR_W;

    // CAS latency: 2 stays 2, 2.5 and 3 become 3 whole cycles.
    always_comb begin
        if (cl_code == 2'd0) lat_cyc = AGE_W'(2);
        else                 lat_cyc = AGE_W'(3);
    end

    // Data cycles per burst: beats divided by two.
    always_comb begin
        case (bl_code)
            2'd0:    half_cyc = AGE_W'(1);
            2'd1:    half_cyc = AGE_W'(2);
            default: half_cyc = AGE_W'(4);
        endcase
    end

    // Recovery count with a floor of one cycle.
    always_comb begin
        if (twr_code == '0) twr_cyc = AGE_W'(1);
        else                twr_cyc = {{PAD_W{1'b0}}, twr_code};
    end

endmodule

// File: rtl/bt_burst_tracker.sv
// Tracks the single burst in progress and derives the data strobes.
// Age counts cycles since the command cycle (age 0). end_age is the last
// busy age: it is shortened by a read cut and replaced by the mask span
// on a write cut. Assumes start is only given when idle and cut only
// when live.
module bt_burst_tracker #(
    parameter int BANK_W = 2,
    parameter int TWR_W  = 4,
    parameter int AGE_W  = TWR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [AGE_W-1:0]  lat_cyc,
    input  logic [AGE_W-1:0]  half_cyc,
    input  logic [AGE_W-1:0]  twr_cyc,
    input  logic              cut,
    output logic              busy,
    output logic              live,
    output logic              is_wr,
    output logic [BANK_W-1:0] bank,
    output logic              rd_valid,
    output logic              wr_window,
    output logic              wr_mask
);
    logic [AGE_W-1:0] age_q;
    logic [AGE_W-1:0] end_q;
    logic [AGE_W-1:0] lat_q;
    logic [AGE_W-1:0] twr_q;
    logic             cut_q;
    logic [AGE_W-1:0] rd_cut_end;

    // Last read age when cut now: terminating command sits at age_q+1.
    assign rd_cut_end = age_q + lat_q;

    // Burst state: capture on start, age and shorten while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            is_wr <= 1'b0;
            cut_q <= 1'b0;
            bank  <= '0;
            age_q <= '0;
            end_q <= '0;
            lat_q <= '0;
            twr_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            is_wr <= start_wr;
            cut_q <= 1'b0;
            bank  <= start_bank;
            age_q <= '0;
            lat_q <= lat_cyc;
            twr_q <= twr_cyc;
            end_q <= start_wr ? half_cyc : (lat_cyc + half_cyc - AGE_W'(1));
        end else if (busy) begin
            if (cut) begin
                cut_q <= 1'b1;
                age_q <= age_q + AGE_W'(1);
                if (is_wr)                  end_q <= age_q + twr_q;
                else if (rd_cut_end < end_q) end_q <= rd_cut_end;
            end else if (age_q == end_q) begin
                busy <= 1'b0;
            end else begin
                age_q <= age_q + AGE_W'(1);
            end
        end
    end

    // Strobes and liveness decoded from the registered state.
    always_comb begin
        live      = busy && !cut_q && (age_q != end_q);
        rd_valid  = busy && !is_wr && (age_q >= lat_q);
        wr_window = busy && is_wr && !cut_q && (age_q != '0);
        wr_mask   = busy && is_wr && cut_q;
    end

endmodule

// File: rtl/bt_cmd_issue.sv
// Decides what each request does and registers the command bus and error.
// Assumes one request per cycle and the tracker state of the same cycle.
module bt_cmd_issue
    import bt_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              busy,
    input  logic              live,
    input  logic              is_wr,
    input  logic [BANK_W-1:0] bank,
    output logic              start,
    output logic              start_wr,
    output logic              cut,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              err
);
    logic       hit;
    logic       nxt_valid;
    logic       nxt_err;
    logic [2:0] nxt_op;

    assign hit = live && (bank == req_bank);

    // Request decode: accept, terminate or refuse.
    always_comb begin
        start     = 1'b0;
        start_wr  = 1'b0;
        cut       = 1'b0;
        nxt_valid = 1'b0;
        nxt_err   = 1'b0;
        nxt_op    = CMD_NOP;
        if (req_valid) begin
            case (req_op)
                REQ_READ, REQ_WRITE: begin
                    if (busy) begin
                        nxt_err = 1'b1;
                    end else begin
                        start     = 1'b1;
                        start_wr  = (req_op == REQ_WRITE);
                        nxt_valid = 1'b1;
                        nxt_op    = (req_op == REQ_WRITE) ? CMD_WRITE : CMD_READ;
                    end
                end
                REQ_PRE: begin
                    nxt_valid = 1'b1;
                    nxt_op    = CMD_PRE;
                    cut       = hit;
                end
                default: begin
                    if (hit && !is_wr) begin
                        nxt_valid = 1'b1;
                        nxt_op    = CMD_BST;
                        cut       = 1'b1;
                    end else begin
                        nxt_err = 1'b1;
                    end
                end
            endcase
        end
    end

    // Command bus and error flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_op    <= CMD_NOP;
            cmd_bank  <= '0;
            err       <= 1'b0;
        end else begin
            cmd_valid <= nxt_valid;
            cmd_op    <= nxt_op;
            cmd_bank  <= nxt_valid ? req_bank : '0;
            err       <= nxt_err;
        end
    end

endmodule

// File: rtl/burst_term_ctrl.sv
// Top of the burst termination controller: command decode, configuration
// decode and the burst tracker. Assumes a single rank with one burst
// in flight at a time.
module burst_term_ctrl #(
    parameter int BANK_W = 2,
    parameter int TWR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [1:0]        cfg_cl,
    input  logic [1:0]        cfg_bl,
    input  logic [TWR_W-1:0]  cfg_twr,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              err,
    output logic              rd_valid,
    output logic              wr_window,
    output logic              wr_mask
);
    localparam int AGE_W = TWR_W + 3;

    logic [AGE_W-1:0]  lat_cyc;
    logic [AGE_W-1:0]  half_cyc;
    logic [AGE_W-1:0]  twr_cyc;
    logic              start;
    logic              start_wr;
    logic              cut;
    logic              busy;
    logic              live;
    logic              is_wr;
    logic [BANK_W-1:0] bank;

    bt_cfg_decode #(.TWR_W(TWR_W), .AGE_W(AGE_W)) u_cfg (
        .cl_code  (cfg_cl),
        .bl_code  (cfg_bl),
        .twr_code (cfg_twr),
        .lat_cyc  (lat_cyc),
        .half_cyc (half_cyc),
        .twr_cyc  (twr_cyc)
    );

    bt_cmd_issue #(.BANK_W(BANK_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_bank  (req_bank),
        .busy      (busy),
        .live      (live),
        .is_wr     (is_wr),
        .bank      (bank),
        .start     (start),
        .start_wr  (start_wr),
        .cut       (cut),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .err       (err)
    );

    bt_burst_tracker #(.BANK_W(BANK_W), .TWR_W(TWR_W), .AGE_W(AGE_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wr   (start_wr),
        .start_bank (req_bank),
        .lat_cyc    (lat_cyc),
        .half_cyc   (half_cyc),
        .twr_cyc    (twr_cyc),
        .cut        (cut),
        .busy       (busy),
        .live       (live),
        .is_wr      (is_wr),
        .bank       (bank),
        .rd_valid   (rd_valid),
        .wr_window  (wr_window),
        .wr_mask    (wr_mask)
    );

endmodule

// File: rtl/bt_checker.sv
// Cycle-by-cycle properties of the burst termination controller's ports.
// Assumes the command code for precharge is 3 and for burst-stop is 4.
module bt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       err,
    input logic       rd_valid,
    input logic       wr_window,
    input logic       wr_mask
);
    // A refused request never shares a cycle with a command.
    assert_err_no_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_valid);

    // Read window never overlaps write data or mask.
    assert_rd_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !(wr_window || wr_mask));

    // Write path is closed whenever the mask is up.
    assert_mask_window_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |-> !wr_window);

    // The mask only starts in a cycle carrying a precharge.
    assert_mask_start_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_mask) |-> (cmd_valid && cmd_op == 3'd3));

    // A burst-stop never goes out while a write is driving or masked.
    assert_no_stop_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |-> !(wr_window || wr_mask));

    // Reset clears every output on the following cycle.
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> !(cmd_valid || err || rd_valid || wr_window || wr_mask));

endmodule

bind burst_term_ctrl bt_checker u_bt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .err       (err),
    .rd_valid  (rd_valid),
    .wr_window (wr_window),
    .wr_mask   (wr_mask)
);

// File: tb/tb_burst_term_ctrl.sv
`timescale 1ns/1ps
module tb_burst_term_ctrl;
    localparam int BANK_W = 2;
    localparam int TWR_W  = 4;
    localparam int NVEC   = 12;
    localparam int SPAN   = 28;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [1:0]        cfg_cl = 2'd0;
    logic [1:0]        cfg_bl = 2'd0;
    logic [TWR_W-1:0]  cfg_twr = '0;
    logic              cmd_valid;
    logic [2:0]        cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic              err;
    logic              rd_valid;
    logic              wr_window;
    logic              wr_mask;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    burst_term_ctrl #(.BANK_W(BANK_W), .TWR_W(TWR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .cfg_twr(cfg_twr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .err(err),
        .rd_valid(rd_valid), .wr_window(wr_window), .wr_mask(wr_mask)
    );

    // Fields: wr, cl, bl, twr, term(0 none/2 pre/3 stop), term cycle,
    //         window first, window last (0,0 = none), mask cycles, err expected
    localparam int VEC [NVEC][10] = '{
        '{0, 0, 1, 0, 0, 0, 2, 3, 0, 0},
        '{0, 2, 2, 0, 0, 0, 3, 6, 0, 0},
        '{0, 1, 0, 0, 0, 0, 3, 3, 0, 0},
        '{0, 0, 2, 0, 2, 1, 2, 2, 0, 0},
        '{0, 2, 2, 0, 3, 2, 3, 4, 0, 0},
        '{0, 0, 2, 0, 2, 5, 2, 5, 0, 0},
        '{1, 0, 1, 0, 0, 0, 1, 2, 0, 0},
        '{1, 0, 2, 3, 2, 2, 1, 1, 3, 0},
        '{1, 0, 2, 5, 3, 2, 1, 4, 0, 1},
        '{1, 0, 2, 0, 2, 3, 1, 2, 1, 0},
        '{0, 1, 2, 0, 2, 1, 3, 3, 0, 0},
        '{1, 0, 1, 2, 2, 1, 0, 0, 2, 0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [1:0] op, input logic [BANK_W-1:0] b);
        req_valid = v;
        req_op    = op;
        req_bank  = b;
    endtask

    function automatic string win_tag(input int wr, input int term);
        if (wr == 0) return (term == 0) ? "R2 read window" : "R3 read cut";
        if (term == 0) return "R4 write window";
        if (term == 3) return "R7 write after refused stop";
        return "R5 write cut";
    endfunction

    task automatic run_vec(input int i);
        int wr, term, d;
        int first, last, mcount, mfirst, other;
        wr = VEC[i][0]; term = VEC[i][4]; d = VEC[i][5];
        first = 0; last = 0; mcount = 0; mfirst = 0; other = 0;
        @(negedge clk);
        cfg_cl  = 2'(VEC[i][1]);
        cfg_bl  = 2'(VEC[i][2]);
        cfg_twr = TWR_W'(VEC[i][3]);
        drive(1'b1, wr ? 2'd1 : 2'd0, 2'd1);
        for (int c = 0; c < SPAN; c++) begin
            @(negedge clk);
            if (c == 0)
                check(cmd_valid && cmd_op == (wr ? 3'd2 : 3'd1) && cmd_bank == 2'd1,
                      "R1 start command", int'(cmd_op), wr ? 2 : 1);
            if (term != 0 && c == d) begin
                if (VEC[i][9] != 0)
                    check(err && !cmd_valid, "R7 stop refused in write",
                          int'(cmd_valid), 0);
                else
                    check(cmd_valid && !err && cmd_op == (term == 2 ? 3'd3 : 3'd4),
                          "R1 terminate command", int'(cmd_op), term == 2 ? 3 : 4);
            end
            if (wr ? wr_window : rd_valid) begin
                if (first == 0) first = c;
                last = c;
            end
            if (wr ? rd_valid : 1'b0) other++;
            if (wr_mask) begin
                if (mcount == 0) mfirst = c;
                mcount++;
            end
            if (term != 0 && c + 1 == d) drive(1'b1, 2'(term), 2'd1);
            else                         drive(1'b0, 2'd0, '0);
        end
        check(first == VEC[i][6], win_tag(wr, term), first, VEC[i][6]);
        check(last == VEC[i][7], win_tag(wr, term), last, VEC[i][7]);
        check(mcount == VEC[i][8], "R6 mask length", mcount, VEC[i][8]);
        check(other == 0, "R4 no read strobe in write", other, 0);
        if (VEC[i][8] != 0)
            check(mfirst == d, "R6 mask start", mfirst, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int first, last;
        repeat (3) @(negedge clk);
        check(!(cmd_valid || err || rd_valid || wr_window || wr_mask),
              "R11 reset state", int'(cmd_valid), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R8: stop with nothing live
        @(negedge clk); drive(1'b1, 2'd3, 2'd0);
        @(negedge clk); drive(1'b0, 2'd0, '0);
        check(err && !cmd_valid, "R8 stop idle refused", int'(err), 1);
        @(negedge clk);
        check(!err, "R8 err single pulse", int'(err), 0);

        // R10: precharge with no burst
        drive(1'b1, 2'd2, 2'd2);
        @(negedge clk); drive(1'b0, 2'd0, '0);
        check(cmd_valid && cmd_op == 3'd3 && cmd_bank == 2'd2 && !err,
              "R10 idle precharge issued", int'(cmd_op), 3);

        // R9/R10: read busy refusal and foreign precharge, read L=2 H=4
        cfg_cl = 2'd0; cfg_bl = 2'd2;
        @(negedge clk); drive(1'b1, 2'd0, 2'd1);
        first = 0; last = 0;
        for (int c = 0; c < SPAN; c++) begin
            @(negedge clk);
            if (c == 1) check(err && !cmd_valid, "R9 busy read refused", int'(err), 1);
            if (c == 2) check(cmd_valid && cmd_op == 3'd3 && cmd_bank == 2'd3 && !err,
                              "R10 foreign precharge issued", int'(cmd_bank), 3);
            if (rd_valid) begin
                if (first == 0) first = c;
                last = c;
            end
            if (c == 0)      drive(1'b1, 2'd0, 2'd1);
            else if (c == 1) drive(1'b1, 2'd2, 2'd3);
            else             drive(1'b0, 2'd0, '0);
        end
        check(first == 2, "R9 window start unchanged", first, 2);
        check(last == 5, "R10 window end unchanged", last, 5);

        // R11: reset mid-burst
        @(negedge clk); drive(1'b1, 2'd0, 2'd0);
        @(negedge clk); drive(1'b0, 2'd0, '0);
        @(negedge clk);
        @(negedge clk);
        check(rd_valid, "R2 read running before reset", int'(rd_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!(rd_valid || cmd_valid || err), "R11 reset mid burst", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!rd_valid, "R11 burst abandoned", int'(rd_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule